// File: doc/BRIEF.md
# Indexed Register Port with Auto-Increment

This block lets a host reach a 256-word internal storage space through only four host addresses. A pointer register selects the internal word, and a data register reads or writes the selected word. Each data access can advance the pointer by one, so the host can stream a whole block of words into or out of the storage without rewriting the pointer.

Two ways of working share one pointer. In the split mode, the host loads the pointer at one address and then moves data through a second address. In the shared mode, a single host address alternates between an index phase and a data phase. A write in the index phase sets the pointer. The following access in the data phase moves the data. A control address holds the auto-increment enable. The pointer is as wide as the storage index, so it wraps from the last word back to word zero.

Host accesses take one cycle. Read data comes back on the cycle after the access, flagged by a one-cycle valid pulse.

Top module: `idxport`

## Requirements
- R1: After synchronous reset: the pointer is 0, the shared port is in its index phase, auto-increment is enabled, every storage word is 0, and `host_rvalid` is low.
- R2: Host address 1 is the pointer register. A write loads the pointer with the low 8 bits of `host_wdata`. A read returns the pointer zero-extended to 32 bits.
- R3: A write to host address 2 stores `host_wdata` at the word the pointer selects. The pointer then increments by one when auto-increment is enabled.
- R4: A read of host address 2 returns the word the pointer selects. The pointer then increments by one when auto-increment is enabled.
- R5: Host address 3 is the control register. Bit 0 enables auto-increment and reads back in bit 0, with all other bits zero. While bit 0 is 0, data accesses leave the pointer unchanged.
- R6: Pointer arithmetic is modulo 256: a data access at word 255 with auto-increment enabled moves the pointer to 0.
- R7: Host address 0 is the shared port. Its phase starts at index and toggles on every host access to address 0, read or write. Accesses to other addresses leave the phase unchanged.
- R8: In the index phase, a write to address 0 loads the pointer from the low 8 bits of `host_wdata`, and a read returns the pointer zero-extended.
- R9: In the data phase, a write to address 0 stores to the selected word and a read of address 0 returns it. In both cases the pointer advances as in R3 and R4.
- R10: `host_rvalid` is high exactly in the cycle after a host read (`host_sel`=1, `host_we`=0), and low otherwise. Cycles with `host_sel`=0 change no state.
- R11: Loading the pointer with 0 and then writing address 2 N times fills words 0..N-1 in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host access strobe, one access per cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Host register select: 0 shared, 1 pointer, 2 data, 3 control |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, valid the cycle after a read |
| host_rvalid | output | 1 | One-cycle pulse marking `host_rdata` valid |

## Verification
The embedded assertions check the following on every cycle:
- the pointer's step of one or hold after each data access, including the wrap at word 255;
- the phase flip on shared-port accesses;
- the contents of a stored word right after the write;
- the timing of the read-valid pulse and the zero upper bits of a pointer read.

Other behaviours need the bench's scenarios, because each depends on a sequence of accesses. These are ordered streaming fills, read-back of a whole block, the interplay of the two modes on one pointer, and the fact that idle cycles change nothing. The bench compares each of these against a reference model of the storage.

// File: rtl/idxport_pkg.sv
package idxport_pkg;

    typedef enum logic [1:0] {
        HA_SHARED = 2'd0,
        HA_PTR    = 2'd1,
        HA_DATA   = 2'd2,
        HA_CTRL   = 2'd3
    } host_reg_e;

    typedef enum logic {
        PH_INDEX = 1'b0,
        PH_DATA  = 1'b1
    } phase_e;

    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_PTR_WR = 3'd1,
        OP_PTR_RD = 3'd2,
        OP_MEM_WR = 3'd3,
        OP_MEM_RD = 3'd4,
        OP_CTL_WR = 3'd5,
        OP_CTL_RD = 3'd6
    } op_e;

    typedef struct packed {
        op_e  op;
        logic flip;   // shared-port phase toggles
    } cmd_t;

    localparam int CTRL_AUTOINC_BIT = 0;

    function automatic logic op_is_mem(op_e op);
        return (op == OP_MEM_WR) || (op == OP_MEM_RD);
    endfunction

    function automatic logic op_is_read(op_e op);
        return (op == OP_PTR_RD) || (op == OP_MEM_RD) || (op == OP_CTL_RD);
    endfunction

    // Map a host access onto an internal operation.
    function automatic cmd_t decode_access(logic sel, logic we, host_reg_e hreg, phase_e ph);
        cmd_t c;
        c.op   = OP_IDLE;
        c.flip = 1'b0;
        if (sel) begin
            unique case (hreg)
                HA_SHARED: begin
                    c.flip = 1'b1;
                    if (ph == PH_INDEX) c.op = we ? OP_PTR_WR : OP_PTR_RD;
                    else                c.op = we ? OP_MEM_WR : OP_MEM_RD;
                end
                HA_PTR:  c.op = we ? OP_PTR_WR : OP_PTR_RD;
                HA_DATA: c.op = we ? OP_MEM_WR : OP_MEM_RD;
                HA_CTRL: c.op = we ? OP_CTL_WR : OP_CTL_RD;
                default: c.op = OP_IDLE;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/idxport_decode.sv
module idxport_decode
    import idxport_pkg::*;
(
    input  logic       host_sel,
    input  logic       host_we,
    input  logic [1:0] host_addr,
    input  phase_e     phase,
    output cmd_t       cmd
);

    always_comb begin
        cmd = decode_access(host_sel, host_we, host_reg_e'(host_addr), phase);
    end

endmodule

// File: rtl/idxport_pointer.sv
module idxport_pointer
    import idxport_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    input  logic [DATA_W-1:0] wdata,
    output logic [IDX_W-1:0]  ptr,
    output phase_e            phase,
    output logic              autoinc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr     <= '0;
            phase   <= PH_INDEX;
            autoinc <= 1'b1;
        end else begin
            unique case (cmd.op)
                OP_PTR_WR: ptr <= wdata[IDX_W-1:0];
                OP_MEM_WR,
                OP_MEM_RD: if (autoinc) ptr <= ptr + IDX_W'(1);
                OP_CTL_WR: autoinc <= wdata[CTRL_AUTOINC_BIT];
                default: ;
            endcase
            if (cmd.flip) phase <= (phase == PH_INDEX) ? PH_DATA : PH_INDEX;
        end
    end

    // R3, R4, R6: a data access with auto-increment steps the pointer by one, modulo the space
    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (op_is_mem(cmd.op) && autoinc) |=> (ptr == $past(ptr) + IDX_W'(1)));

    // R5: with auto-increment off, data accesses hold the pointer
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (op_is_mem(cmd.op) && !autoinc) |=> $stable(ptr));

    // R7: phase flips on shared-port accesses and only then
    a_r7_flip: assert property (@(posedge clk) disable iff (rst)
        cmd.flip |=> (phase != $past(phase)));
    a_r7_keep: assert property (@(posedge clk) disable iff (rst)
        !cmd.flip |=> $stable(phase));

endmodule

// File: rtl/idxport_store.sv
module idxport_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
        end else if (wr_en) begin
            words[addr] <= wdata;
        end
    end

    assign rdata = words[addr];

    // R3: the written word holds the written value on the next cycle
    a_r3_store: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (words[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/idxport.sv
module idxport
    import idxport_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_sel,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid
);

    cmd_t              cmd;
    phase_e            phase;
    logic [IDX_W-1:0]  ptr;
    logic              autoinc;
    logic [DATA_W-1:0] word_q;

    idxport_decode u_decode (
        .host_sel  (host_sel),
        .host_we   (host_we),
        .host_addr (host_addr),
        .phase     (phase),
        .cmd       (cmd)
    );

    idxport_pointer #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_pointer (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .wdata   (host_wdata),
        .ptr     (ptr),
        .phase   (phase),
        .autoinc (autoinc)
    );

    idxport_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .wr_en (cmd.op == OP_MEM_WR),
        .addr  (ptr),
        .wdata (host_wdata),
        .rdata (word_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
        end else begin
            host_rvalid <= op_is_read(cmd.op);
            unique case (cmd.op)
                OP_PTR_RD: host_rdata <= DATA_W'(ptr);
                OP_MEM_RD: host_rdata <= word_q;
                OP_CTL_RD: host_rdata <= DATA_W'(autoinc);
                default: ;
            endcase
        end
    end

    // R10: valid pulse follows each host read; writes never raise it
    a_r10_after_read: assert property (@(posedge clk) disable iff (rst)
        (host_sel && !host_we) |=> host_rvalid);
    a_r10_no_write_valid: assert property (@(posedge clk) disable iff (rst)
        (host_sel && host_we) |=> !host_rvalid);
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !host_sel |=> !host_rvalid);

    // R2: pointer reads carry zero upper bits
    a_r2_ptr_zext: assert property (@(posedge clk) disable iff (rst)
        (host_sel && !host_we && host_addr == 2'd1) |=> (host_rdata[DATA_W-1:IDX_W] == '0));

endmodule

// File: tb/idxport_bench.sv
module idxport_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_sel = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_rvalid;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model
    logic [31:0] mem_m [256];
    int          ptr_m;
    bit          phase_m;
    bit          ai_m;

    always #5 clk = ~clk;

    idxport u_idxport (
        .clk(clk), .rst(rst), .host_sel(host_sel), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid)
    );

    task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < 256; i++) mem_m[i] = '0;
        ptr_m = 0; phase_m = 0; ai_m = 1;
    endfunction

    function automatic logic [31:0] model_mem(bit we, logic [31:0] d);
        logic [31:0] r = '0;
        if (we) mem_m[ptr_m] = d; else r = mem_m[ptr_m];
        if (ai_m) ptr_m = (ptr_m + 1) % 256;
        return r;
    endfunction

    // Expected read data per requirements, updating the model
    function automatic logic [31:0] model_access(bit we, int a, logic [31:0] d);
        logic [31:0] r = '0;
        case (a)
            0: begin
                if (!phase_m) begin
                    if (we) ptr_m = int'(d[7:0]); else r = 32'(ptr_m);
                end else r = model_mem(we, d);
                phase_m = !phase_m;
            end
            1: if (we) ptr_m = int'(d[7:0]); else r = 32'(ptr_m);
            2: r = model_mem(we, d);
            default: if (we) ai_m = d[0]; else r = {31'b0, ai_m};
        endcase
        return r;
    endfunction

    // One host access; read data checked the cycle after
    task automatic access(bit we, int a, logic [31:0] d, string tag);
        logic [31:0] exp;
        @(negedge clk);
        host_sel = 1'b1; host_we = we; host_addr = 2'(a); host_wdata = d;
        exp = model_access(we, a, d);
        @(negedge clk);
        host_sel = 1'b0; host_we = 1'b0;
        if (!we) begin
            check32({tag, " rvalid"}, 32'(host_rvalid), 32'd1);
            check32({tag, " rdata"}, host_rdata, exp);
        end else begin
            check32({tag, " rvalid after write"}, 32'(host_rvalid), 32'd0);
        end
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] vals [16];
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state
        check32("R1 rvalid", 32'(host_rvalid), 32'd0);
        access(0, 1, 0, "R1 pointer");
        access(0, 3, 0, "R1 control");
        access(0, 2, 0, "R1 storage cleared");
        access(0, 1, 0, "R1 pointer after read");

        // R2: pointer load keeps low 8 bits
        access(1, 1, 32'hABCD_1234, "R2 load");
        access(0, 1, 0, "R2 readback");

        // R11 / R3: stream fill from zero, then R4 read back
        access(1, 1, 0, "R11 set zero");
        for (int i = 0; i < 16; i++) begin
            vals[i] = $urandom;
            access(1, 2, vals[i], "R11 fill");
        end
        access(0, 1, 0, "R3 pointer advanced");
        access(1, 1, 0, "R4 rewind");
        for (int i = 0; i < 16; i++) access(0, 2, 0, "R4 stream read");
        access(0, 1, 0, "R4 pointer advanced");

        // R6: wrap at top of space
        access(1, 1, 255, "R6 set 255");
        access(1, 2, 32'hFEED_0FF0, "R6 write top");
        access(0, 1, 0, "R6 wrapped to 0");
        access(1, 1, 255, "R6 reset 255");
        access(0, 2, 0, "R6 read top");
        access(0, 1, 0, "R6 wrapped after read");

        // R5: auto-increment disabled
        access(1, 3, 0, "R5 disable");
        access(0, 3, 0, "R5 ctrl readback");
        access(1, 1, 10, "R5 set");
        access(1, 2, 32'h1111_1111, "R5 write a");
        access(1, 2, 32'h2222_2222, "R5 write b");
        access(0, 1, 0, "R5 pointer held");
        access(0, 2, 0, "R5 read same word");
        access(1, 3, 1, "R5 enable");
        access(0, 3, 0, "R5 ctrl on");

        // R7/R8/R9: shared single-address port
        access(1, 0, 40, "R8 index write");
        access(1, 0, 32'hC0DE_CAFE, "R9 data write");
        access(0, 0, 0, "R8 index read");
        access(0, 0, 0, "R9 data read");
        access(1, 1, 2, "R7 ptr via addr1 keeps phase");
        access(0, 0, 0, "R7 still index phase");
        access(1, 1, 40, "R9 check set");
        access(0, 2, 0, "R9 stored word");

        // R10: idle cycles with write-like inputs change nothing
        @(negedge clk);
        host_sel = 1'b0; host_we = 1'b1; host_addr = 2'd2; host_wdata = 32'hDEAD_BEEF;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check32("R10 idle rvalid", 32'(host_rvalid), 32'd0);
        end
        host_addr = 2'd1;
        repeat (2) @(negedge clk);
        host_we = 1'b0;
        access(0, 1, 0, "R10 pointer untouched");
        access(0, 2, 0, "R10 word untouched");

        // random mix
        for (int i = 0; i < 800; i++) begin
            int a;
            bit we;
            logic [31:0] d;
            int pick = int'($urandom % 20);
            a  = (pick < 5) ? 0 : (pick < 8) ? 1 : (pick < 18) ? 2 : 3;
            we = $urandom % 2;
            d  = $urandom;
            if (a == 3 && we) d = ($urandom % 4 == 0) ? 32'd0 : 32'd1;
            access(we, a, d, "R9 R3 R4 random");
        end
        access(0, 1, 0, "R2 final pointer");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule